// File: doc/BRIEF.md
# Power Mode Clock Controller

This block produces the clock enables for a small processor core and its peripherals, and it tracks which of five power states the core is in. An oscillator-rate clock drives everything. The block divides that clock into single-cycle enable pulses instead of real gated clocks. In normal operation the pulses come at half the oscillator rate. A slow option lowers the rate to one of four slower values.

A narrow configuration port writes a slow enable bit and a two-bit rate select. Two strobes stand in for the processor's sleep instructions: one asks to wait and one asks to halt. While waiting, the core's enable stops and the peripherals keep their rate. While halted, both enables stop and the slow bit is cleared. A wake input (an interrupt or a reset event) ends either sleep. A change of rate never takes effect in the middle of a divider period. This means a pulse can never arrive early or late.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: While `rst` is high, `cpu_ce` and `per_ce` are 0 and `mode` is 0 (RUN). After release, both enables pulse every 2 cycles. The first pulse is seen in the cycle after the second rising edge with `rst` low.
- R2: With the slow bit set, the enable period is 4, 8, 16 or 32 cycles for select codes 00, 01, 10 and 11. `mode` reads 1 (SLOW) while a slow rate is in effect.
- R3: While the slow bit is clear, the select field has no effect: the period stays 2 and `mode` stays 0.
- R4: A new rate or slow setting is applied only when the divider count wraps. The gap between consecutive `per_ce` pulses is therefore always a full period of 2, 4, 8, 16 or 32 cycles, unless a HALT comes between them.
- R5: In RUN and SLOW, `cpu_ce` and `per_ce` pulse in the same cycles.
- R6: A `wait_req` in RUN enters WAIT (`mode` 2). In WAIT, `cpu_ce` stays 0 and `per_ce` keeps its current rate.
- R7: A `wait_req` while a slow rate is in effect enters SLOW-WAIT (`mode` 3). While waiting, the mode reads 3 whenever a slow rate is in effect and 2 otherwise.
- R8: A `halt_req` in RUN or SLOW enters HALT (`mode` 4). Both enables stay 0 and the slow bit is cleared. A `wake` returns the block to RUN (`mode` 0) at the /2 rate.
- R9: A `wake` in WAIT or SLOW-WAIT returns the block to RUN or SLOW. In RUN and SLOW, `wake` has no effect.
- R10: If `halt_req` and `wait_req` arrive in the same cycle, HALT wins. Both requests are ignored while in WAIT or HALT.
- R11: A configuration write (`cfg_we`) is discarded while in HALT and in the cycle that enters HALT.
- R12: `mode` only ever takes the codes 0 to 4 listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slow | input | 1 | Slow enable value to write |
| cfg_sel | input | SEL_W | Slow rate select value to write |
| wait_req | input | 1 | Wait request strobe |
| halt_req | input | 1 | Halt request strobe |
| wake | input | 1 | Wake-up event (interrupt or reset) |
| cpu_ce | output | 1 | Core clock enable pulse |
| per_ce | output | 1 | Peripheral clock enable pulse |
| mode | output | 3 | Current power state code |

## Verification
All three outputs are registered one edge after the internal divider tick and state register. An input sampled at an edge therefore changes the state at that edge, and `mode` and the enables show the change at the next edge. A new rate shows only after the current period has wrapped, which can be up to 32 cycles later.

The bench drives inputs on the falling edge. It advances a cycle-accurate expected-value model in the same step, and it compares every output at the next falling edge against the values the model predicted for the rising edge just passed. Checks therefore land exactly on the cycle each result is due. The bench never waits for a result to appear.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    ST_ACT  = 2'd0,
    ST_WAIT = 2'd1,
    ST_HALT = 2'd2
  } pm_state_e;

  localparam logic [2:0] MODE_RUN       = 3'd0;
  localparam logic [2:0] MODE_SLOW      = 3'd1;
  localparam logic [2:0] MODE_WAIT      = 3'd2;
  localparam logic [2:0] MODE_SLOW_WAIT = 3'd3;
  localparam logic [2:0] MODE_HALT      = 3'd4;

  function automatic logic [2:0] mode_code(input pm_state_e st, input logic slow_act);
    logic [2:0] m;
    case (st)
      ST_ACT:  m = slow_act ? MODE_SLOW : MODE_RUN;
      ST_WAIT: m = slow_act ? MODE_SLOW_WAIT : MODE_WAIT;
      ST_HALT: m = MODE_HALT;
      default: m = MODE_RUN;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pmc_cfg_reg.sv
module pmc_cfg_reg #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             wr_slow,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             halted,
  input  logic             halt_enter,
  output logic             slow_q,
  output logic [SEL_W-1:0] sel_q
);

  logic write_ok;

  // Writes are refused while halted and on the edge that enters halt.
  assign write_ok = we && !halted && !halt_enter;

  always_ff @(posedge clk) begin
    if (rst) begin
      slow_q <= 1'b0;
      sel_q  <= '0;
    end else if (halt_enter) begin
      slow_q <= 1'b0;
    end else if (write_ok) begin
      slow_q <= wr_slow;
      sel_q  <= wr_sel;
    end
  end

endmodule

// File: rtl/pmc_divider.sv
module pmc_divider #(
  parameter int SEL_W    = 2,
  parameter int BASE_EXP = 1,
  parameter int SLOW_OFS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             slow_q,
  input  logic [SEL_W-1:0] sel_q,
  output logic             tick,
  output logic             slow_active
);

  localparam int MAX_EXP = SLOW_OFS + (2 ** SEL_W) - 1;
  localparam int EXP_W   = $clog2(MAX_EXP + 1);
  localparam int CNT_W   = MAX_EXP;

  logic [CNT_W-1:0] cnt_q;
  logic [EXP_W-1:0] exp_q;
  logic [EXP_W-1:0] req_exp;
  logic [CNT_W-1:0] limit;

  // Terminal count for a power-of-two period: low exp bits set.
  function automatic logic [CNT_W-1:0] term_count(input logic [EXP_W-1:0] e);
    logic [CNT_W-1:0] v;
    v = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (EXP_W'(i) < e) v[i] = 1'b1;
    end
    return v;
  endfunction

  assign req_exp = slow_q ? (EXP_W'(sel_q) + EXP_W'(SLOW_OFS)) : EXP_W'(BASE_EXP);
  assign limit   = term_count(exp_q);
  assign tick    = !hold && (cnt_q == limit);
  assign slow_active = (exp_q != EXP_W'(BASE_EXP));

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt_q <= '0;
      exp_q <= EXP_W'(BASE_EXP);
    end else if (tick) begin
      // Rate changes land only here, on the wrap.
      cnt_q <= '0;
      exp_q <= req_exp;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wait_req,
  input  logic      halt_req,
  input  logic      wake,
  output pm_state_e state,
  output logic      halt_enter
);

  pm_state_e state_d;

  always_comb begin
    state_d    = state;
    halt_enter = 1'b0;
    case (state)
      ST_ACT: begin
        if (halt_req) begin
          state_d    = ST_HALT;
          halt_enter = 1'b1;
        end else if (wait_req) begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: if (wake) state_d = ST_ACT;
      ST_HALT: if (wake) state_d = ST_ACT;
      default: state_d = ST_ACT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_ACT;
    else     state <= state_d;
  end

endmodule

// File: rtl/pmc_out_stage.sv
module pmc_out_stage
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  pm_state_e state,
  input  logic      slow_active,
  output logic      cpu_ce,
  output logic      per_ce,
  output logic [2:0] mode
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_ce <= 1'b0;
      per_ce <= 1'b0;
      mode   <= MODE_RUN;
    end else begin
      cpu_ce <= tick && (state == ST_ACT);
      per_ce <= tick && (state != ST_HALT);
      mode   <= mode_code(state, slow_active);
    end
  end

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pmc_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int BASE_EXP = 1,
  parameter int SLOW_OFS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_slow,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             wait_req,
  input  logic             halt_req,
  input  logic             wake,
  output logic             cpu_ce,
  output logic             per_ce,
  output logic [2:0]       mode
);

  pm_state_e        state;
  logic             halt_enter;
  logic             slow_q;
  logic [SEL_W-1:0] sel_q;
  logic             tick;
  logic             slow_active;
  logic             halted;

  assign halted = (state == ST_HALT);

  pmc_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .wait_req   (wait_req),
    .halt_req   (halt_req),
    .wake       (wake),
    .state      (state),
    .halt_enter (halt_enter)
  );

  pmc_cfg_reg #(.SEL_W(SEL_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .we         (cfg_we),
    .wr_slow    (cfg_slow),
    .wr_sel     (cfg_sel),
    .halted     (halted),
    .halt_enter (halt_enter),
    .slow_q     (slow_q),
    .sel_q      (sel_q)
  );

  pmc_divider #(
    .SEL_W    (SEL_W),
    .BASE_EXP (BASE_EXP),
    .SLOW_OFS (SLOW_OFS)
  ) u_div (
    .clk         (clk),
    .rst         (rst),
    .hold        (halted),
    .slow_q      (slow_q),
    .sel_q       (sel_q),
    .tick        (tick),
    .slow_active (slow_active)
  );

  pmc_out_stage u_out (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .state       (state),
    .slow_active (slow_active),
    .cpu_ce      (cpu_ce),
    .per_ce      (per_ce),
    .mode        (mode)
  );

endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
module pwr_clk_ctrl_chk #(
  parameter int SEL_W    = 2,
  parameter int BASE_EXP = 1,
  parameter int SLOW_OFS = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       cpu_ce,
  input logic       per_ce,
  input logic [2:0] mode
);

  localparam int MAX_EXP = SLOW_OFS + (2 ** SEL_W) - 1;
  localparam int GAP_W   = MAX_EXP + 2;

  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] gap_p1;
  logic             seen_q;

  assign gap_p1 = gap_q + GAP_W'(1);

  // Cycles since the previous peripheral pulse; a halt restarts the tracking.
  always_ff @(posedge clk) begin
    if (rst || mode == 3'd4) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (per_ce) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_p1 != '0) begin
      gap_q  <= gap_p1;
    end
  end

  a_r4_full_period: assert property (@(posedge clk) disable iff (rst)
    (per_ce && seen_q) |-> ($countones(gap_p1) == 1 &&
                            gap_p1 >= GAP_W'(2 ** BASE_EXP) &&
                            gap_p1 <= GAP_W'(2 ** MAX_EXP)));

  a_r5_lockstep: assert property (@(posedge clk) disable iff (rst)
    (mode <= 3'd1) |-> (cpu_ce == per_ce));

  a_r6_wait_core_off: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd2 || mode == 3'd3) |-> !cpu_ce);

  a_r8_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd4) |-> (!cpu_ce && !per_ce));

  a_r8_halt_exit_run: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 3'd4 && mode != 3'd4) |-> (mode == 3'd0));

  a_r12_mode_legal: assert property (@(posedge clk) disable iff (rst)
    mode <= 3'd4);

endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk #(
  .SEL_W    (SEL_W),
  .BASE_EXP (BASE_EXP),
  .SLOW_OFS (SLOW_OFS)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cpu_ce (cpu_ce),
  .per_ce (per_ce),
  .mode   (mode)
);

// File: tb/pwr_clk_ctrl_tb.sv
module pwr_clk_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic       cfg_slow = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic       wait_req = 1'b0;
  logic       halt_req = 1'b0;
  logic       wake = 1'b0;
  logic       cpu_ce;
  logic       per_ce;
  logic [2:0] mode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Expected-value model: 0 = active, 1 = waiting, 2 = halted.
  int       m_st = 0;
  int       m_cnt = 0;
  int       m_exp = 1;
  bit       m_slow = 1'b0;
  int       m_sel = 0;
  bit       e_cpu = 1'b0;
  bit       e_per = 1'b0;
  logic [2:0] e_mode = 3'd0;

  pwr_clk_ctrl u_dut (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_slow (cfg_slow),
    .cfg_sel  (cfg_sel),
    .wait_req (wait_req),
    .halt_req (halt_req),
    .wake     (wake),
    .cpu_ce   (cpu_ce),
    .per_ce   (per_ce),
    .mode     (mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] exp_mode(input int st, input int ex);
    if (st == 2) return 3'd4;
    if (st == 1) return (ex != 1) ? 3'd3 : 3'd2;
    return (ex != 1) ? 3'd1 : 3'd0;
  endfunction

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R6";
      3'd3: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Predict the outputs and state after the coming rising edge.
  task automatic model_adv();
    bit tick;
    int req;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_exp = 1; m_slow = 0; m_sel = 0;
      e_cpu = 0; e_per = 0; e_mode = 3'd0;
      return;
    end
    tick   = (m_st != 2) && (m_cnt == (1 << m_exp) - 1);
    e_cpu  = tick && (m_st == 0);
    e_per  = tick && (m_st != 2);
    e_mode = exp_mode(m_st, m_exp);
    req    = m_slow ? (m_sel + 2) : 1;
    if (m_st == 0 && halt_req) m_slow = 0;
    else if (cfg_we && m_st != 2) begin m_slow = cfg_slow; m_sel = int'(cfg_sel); end
    if (m_st == 2) begin m_cnt = 0; m_exp = 1; end
    else if (tick) begin m_cnt = 0; m_exp = req; end
    else m_cnt = m_cnt + 1;
    case (m_st)
      0: if (halt_req) m_st = 2; else if (wait_req) m_st = 1;
      default: if (wake) m_st = 0;
    endcase
  endtask

  task automatic cmp(input string tag);
    checks += 3;
    if (cpu_ce !== e_cpu) begin
      failures++;
      $display("FAIL %s cpu_ce actual=%0b expected=%0b t=%0t", tag, cpu_ce, e_cpu, $time);
    end
    if (per_ce !== e_per) begin
      failures++;
      $display("FAIL %s per_ce actual=%0b expected=%0b t=%0t", tag, per_ce, e_per, $time);
    end
    if (mode !== e_mode) begin
      failures++;
      $display("FAIL %s mode actual=%0d expected=%0d t=%0t", tag, mode, e_mode, $time);
    end
  endtask

  task automatic step(input bit r, input bit we, input bit sl, input logic [1:0] se,
                      input bit wr, input bit hr, input bit wk, input string tag);
    @(negedge clk);
    cmp(tag);
    rst = r; cfg_we = we; cfg_slow = sl; cfg_sel = se;
    wait_req = wr; halt_req = hr; wake = wk;
    model_adv();
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 2'd0, 0, 0, 0, tag);
  endtask

  task automatic wr_cfg(input bit sl, input logic [1:0] se, input string tag);
    step(0, 1, sl, se, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYC);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357_9bdf));
    model_adv();
    // R1: reset state and base rate
    for (int i = 0; i < 3; i++) step(1, 0, 0, 2'd0, 0, 0, 0, "R1");
    idle(10, "R1");
    // R3: select alone does nothing while slow is off
    wr_cfg(0, 2'd3, "R3");
    idle(12, "R3");
    // R2 / R4 / R5: each slow rate, written mid-period
    for (int s = 0; s < 4; s++) begin
      idle(1, "R4");
      wr_cfg(1, 2'(s), "R4");
      idle(40 + 8 * s, "R5");
    end
    wr_cfg(1, 2'd0, "R2");
    idle(12, "R2");
    // R7 / R9: slow wait and wake
    step(0, 0, 0, 2'd0, 1, 0, 0, "R7");
    idle(20, "R7");
    step(0, 0, 0, 2'd0, 0, 0, 1, "R9");
    idle(10, "R9");
    // R6 / R10: plain wait ignores halt, then wake
    wr_cfg(0, 2'd0, "R6");
    idle(8, "R6");
    step(0, 0, 0, 2'd0, 1, 0, 0, "R6");
    idle(6, "R6");
    step(0, 0, 0, 2'd0, 0, 1, 0, "R10");
    idle(6, "R10");
    step(0, 0, 0, 2'd0, 0, 0, 1, "R9");
    idle(6, "R9");
    step(0, 0, 0, 2'd0, 0, 0, 1, "R9");
    idle(6, "R9");
    // R8 / R11: halt from slow, write refused, wake to run
    wr_cfg(1, 2'd1, "R8");
    idle(20, "R8");
    step(0, 0, 0, 2'd0, 0, 1, 0, "R8");
    idle(5, "R8");
    wr_cfg(1, 2'd2, "R11");
    idle(5, "R11");
    step(0, 0, 0, 2'd0, 0, 0, 1, "R8");
    idle(20, "R11");
    // R10: simultaneous wait and halt; R11: write on the halt edge
    step(0, 1, 1, 2'd3, 1, 1, 0, "R10");
    idle(4, "R10");
    step(0, 0, 0, 2'd0, 0, 0, 1, "R11");
    idle(12, "R11");
    // Random mix, tagged by the expected mode (R12 covers the code set)
    for (int i = 0; i < 4000; i++) begin
      bit we, sl, wr, hr, wk;
      logic [1:0] se;
      we = ($urandom_range(0, 15) == 0);
      sl = $urandom_range(0, 1) == 1;
      se = 2'($urandom_range(0, 3));
      wr = ($urandom_range(0, 19) == 0);
      hr = ($urandom_range(0, 59) == 0);
      wk = ($urandom_range(0, 9) == 0);
      step(0, we, sl, se, wr, hr, wk, (i % 7 == 0) ? "R12" : tag_of(e_mode));
    end
    @(negedge clk);
    cmp("R12");
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule